// File: doc/BRIEF.md
# Subbanked Slow-Write Memory Array

This block is a word-addressed storage array cut into several subbanks, built for a storage technology whose writes take many clock cycles while reads are fast. Every subbank owns a one-entry write buffer. A write request is taken from the shared write port in a single cycle and parked in the buffer of its subbank. The subbank then spends a configurable number of cycles committing it, while the shared port is already free for a write to any other subbank. Only the bits that differ from the stored word are committed. A write that changes nothing never occupies the buffer.

Reads travel on a separate port that reaches every subbank and never waits for the write path. A read of a word whose write is still parked in a buffer gets the parked data. Any other read gets the array contents. Two address mappings are offered. The striped mapping takes the subbank from the low address bits. In register-file use the address is {thread, register}, so consecutive registers of one thread fall into different subbanks and can be written back to back. The blocked mapping takes the subbank from the high address bits.

Top module: `sbk_mem_array`

## Requirements
- R1: After reset every word reads as zero, `sb_busy` is all zero, `wr_ready` is high and `rd_resp_valid` is low.
- R2: A write is taken on a rising edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low exactly when the subbank addressed by `wr_addr` is busy, and the requester holds its request until it is taken.
- R3: A taken write whose data differs from the stored word raises `sb_busy` of its subbank from the next cycle on, for exactly WRITE_CYCLES cycles. Other subbanks stay free and accept writes during that time.
- R4: A taken write whose data equals the stored word leaves `sb_busy` low, and the subbank accepts a new write in the very next cycle.
- R5: A read request sampled on an edge with `rd_valid` high gives `rd_resp_valid` high in the following cycle, with `rd_resp_data` valid in that cycle. No read is ever stalled.
- R6: A read of the address whose write is parked in its subbank's buffer returns the parked data.
- R7: A read of a busy subbank at an address other than the parked one returns the array contents, with no delay.
- R8: Once the commit ends, reads of that address return the written word. The array changes only in the bits that differ.
- R9: In the default striped mapping (MAP_STRIPED), the subbank index is `addr[SB_W-1:0]` and the row is the remaining upper bits. With a 4-bit register field, register r of thread t at address t*16+r lands in subbank r mod NUM_SUBBANKS.
- R10: A read sampled on the same edge that takes a write to the same address returns the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Addressed subbank can take the write |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write data |
| rd_valid | input | 1 | Read request present |
| rd_addr | input | ADDR_W | Read word address |
| rd_resp_valid | output | 1 | Read response valid, one cycle after the request |
| rd_resp_data | output | DATA_W | Read response data |
| sb_busy | output | NUM_SUBBANKS | Per-subbank commit in progress |

## Verification
`wr_ready` is due in the same cycle as the request, because it depends only on the busy state and the request address. A differing write shows on `sb_busy` in the cycle after the edge that takes it, and that bit drops WRITE_CYCLES cycles later. A read answer appears in the cycle after its request edge and reflects the state from before that edge. The bench's behavioural model moves forward at each rising edge and records what each output should be for the cycle that follows. It compares those values with the ports at the falling edge, half a period away from any input change, so each result is checked in exactly the cycle it is due.

// File: rtl/sbk_pkg.sv
package sbk_pkg;

  // How a flat word address is split into subbank index and row
  typedef enum logic {
    MAP_STRIPED = 1'b0,  // subbank from low address bits
    MAP_BLOCKED = 1'b1   // subbank from high address bits
  } map_mode_e;

  // Width of a down-counter that must hold the value n
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/sbk_addr_map.sv
module sbk_addr_map
  import sbk_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned SB_W     = 2,
  parameter map_mode_e   MAP_MODE = MAP_STRIPED,
  localparam int unsigned ROW_W   = ADDR_W - SB_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [SB_W-1:0]   sb_idx,
  output logic [ROW_W-1:0]  row
);

  generate
    if (MAP_MODE == MAP_STRIPED) begin : g_striped
      // neighbouring words go to neighbouring subbanks
      assign sb_idx = addr[SB_W-1:0];
      assign row    = addr[ADDR_W-1:SB_W];
    end else begin : g_blocked
      // each subbank owns one contiguous slice of the address space
      assign sb_idx = addr[ADDR_W-1:ROW_W];
      assign row    = addr[ROW_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/sbk_subbank.sv
module sbk_subbank
  import sbk_pkg::*;
#(
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned ROW_W        = 4,
  parameter int unsigned WRITE_CYCLES = 8,
  localparam int unsigned ROWS        = 1 << ROW_W,
  localparam int unsigned CNT_W       = cnt_width(WRITE_CYCLES)
) (
  input  logic              clk,
  input  logic              rst,
  // write side: wr_take is only raised while busy is low
  input  logic              wr_take,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [DATA_W-1:0] wr_data,
  output logic              busy,
  // independent read side, combinational lookup
  input  logic [ROW_W-1:0]  rd_row,
  output logic [DATA_W-1:0] rd_word
);

  logic [DATA_W-1:0] cells [ROWS];

  // one-entry write buffer
  logic              pend;
  logic [ROW_W-1:0]  pend_row;
  logic [DATA_W-1:0] pend_data;
  logic [DATA_W-1:0] pend_mask;
  logic [CNT_W-1:0]  remain;

  // bits that the incoming write would flip
  logic [DATA_W-1:0] flip;
  assign flip = wr_data ^ cells[wr_row];

  logic commit_now;
  assign commit_now = pend && (remain == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < ROWS; r++) cells[r] <= '0;
      pend      <= 1'b0;
      pend_row  <= '0;
      pend_data <= '0;
      pend_mask <= '0;
      remain    <= '0;
    end else begin
      if (pend) begin
        if (commit_now) begin
          // bit-selective commit: untouched bits keep their old value
          cells[pend_row] <= (cells[pend_row] & ~pend_mask) | (pend_data & pend_mask);
          pend            <= 1'b0;
          remain          <= '0;
        end else begin
          remain <= remain - CNT_W'(1);
        end
      end
      if (wr_take && (flip != '0)) begin
        pend      <= 1'b1;
        pend_row  <= wr_row;
        pend_data <= wr_data;
        pend_mask <= flip;
        remain    <= CNT_W'(WRITE_CYCLES);
      end
    end
  end

  assign busy = pend;

  // forward the parked word when the read hits its row
  logic hit_pend;
  assign hit_pend = pend && (pend_row == rd_row);
  assign rd_word  = hit_pend ? pend_data : cells[rd_row];

endmodule

// File: rtl/sbk_mem_array.sv
module sbk_mem_array
  import sbk_pkg::*;
#(
  parameter int unsigned NUM_SUBBANKS = 4,
  parameter int unsigned ADDR_W       = 6,
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned WRITE_CYCLES = 8,
  parameter map_mode_e   MAP_MODE     = MAP_STRIPED,
  localparam int unsigned SB_W        = $clog2(NUM_SUBBANKS),
  localparam int unsigned ROW_W       = ADDR_W - SB_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    rd_valid,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic                    rd_resp_valid,
  output logic [DATA_W-1:0]       rd_resp_data,
  output logic [NUM_SUBBANKS-1:0] sb_busy
);

  logic [SB_W-1:0]   wr_sb;
  logic [ROW_W-1:0]  wr_row;
  logic [SB_W-1:0]   rd_sb;
  logic [ROW_W-1:0]  rd_row;
  logic [DATA_W-1:0] sb_rd_word [NUM_SUBBANKS];
  logic [NUM_SUBBANKS-1:0] busy_vec;

  sbk_addr_map #(
    .ADDR_W(ADDR_W), .SB_W(SB_W), .MAP_MODE(MAP_MODE)
  ) u_wr_map (
    .addr(wr_addr), .sb_idx(wr_sb), .row(wr_row)
  );

  sbk_addr_map #(
    .ADDR_W(ADDR_W), .SB_W(SB_W), .MAP_MODE(MAP_MODE)
  ) u_rd_map (
    .addr(rd_addr), .sb_idx(rd_sb), .row(rd_row)
  );

  // the shared write path stalls only on the addressed subbank
  assign wr_ready = ~busy_vec[wr_sb];

  generate
    for (genvar s = 0; s < NUM_SUBBANKS; s++) begin : g_sb
      logic take;
      assign take = wr_valid && wr_ready && (wr_sb == SB_W'(s));

      sbk_subbank #(
        .DATA_W(DATA_W), .ROW_W(ROW_W), .WRITE_CYCLES(WRITE_CYCLES)
      ) u_sb (
        .clk     (clk),
        .rst     (rst),
        .wr_take (take),
        .wr_row  (wr_row),
        .wr_data (wr_data),
        .busy    (busy_vec[s]),
        .rd_row  (rd_row),
        .rd_word (sb_rd_word[s])
      );
    end
  endgenerate

  assign sb_busy = busy_vec;

  // registered read response, fixed one-cycle latency
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_resp_valid <= 1'b0;
      rd_resp_data  <= '0;
    end else begin
      rd_resp_valid <= rd_valid;
      if (rd_valid) rd_resp_data <= sb_rd_word[rd_sb];
    end
  end

endmodule

// File: rtl/sbk_mem_array_chk.sv
module sbk_mem_array_chk #(
  parameter int unsigned NUM_SUBBANKS = 4,
  parameter int unsigned WRITE_CYCLES = 8,
  localparam int unsigned RUN_W       = $clog2(WRITE_CYCLES + 2)
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    wr_valid,
  input logic                    wr_ready,
  input logic                    rd_valid,
  input logic                    rd_resp_valid,
  input logic [NUM_SUBBANKS-1:0] sb_busy
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (sb_busy == '0 && !rd_resp_valid));

  // R2
  stall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_ready |-> (sb_busy != '0));

  // R5
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> rd_resp_valid);

  // R5
  rd_no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |=> !rd_resp_valid);

  generate
    for (genvar s = 0; s < NUM_SUBBANKS; s++) begin : g_run
      logic [RUN_W-1:0] run;
      always_ff @(posedge clk) begin
        if (rst)             run <= '0;
        else if (sb_busy[s]) run <= run + RUN_W'(1);
        else                 run <= '0;
      end

      // R3
      busy_length_chk: assert property (@(posedge clk) disable iff (rst)
        (!sb_busy[s] && run != '0) |-> (run == RUN_W'(WRITE_CYCLES)));

      // R3
      busy_bound_chk: assert property (@(posedge clk) disable iff (rst)
        sb_busy[s] |-> (run < RUN_W'(WRITE_CYCLES)));

      // R4
      busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sb_busy[s]) |-> $past(wr_valid && wr_ready));
    end
  endgenerate

endmodule

bind sbk_mem_array sbk_mem_array_chk #(
  .NUM_SUBBANKS(NUM_SUBBANKS),
  .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .wr_valid      (wr_valid),
  .wr_ready      (wr_ready),
  .rd_valid      (rd_valid),
  .rd_resp_valid (rd_resp_valid),
  .sb_busy       (sb_busy)
);

// File: tb/test_sbk_mem_array.sv
`timescale 1ns/1ps
module test_sbk_mem_array;

  localparam int NSB   = 4;
  localparam int AW    = 6;
  localparam int DW    = 16;
  localparam int WC    = 8;
  localparam int WORDS = 1 << AW;
  localparam real HALF = 4.0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_valid = 1'b0, rd_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, rd_resp_valid;
  logic [DW-1:0] rd_resp_data;
  logic [NSB-1:0] sb_busy;

  always #(HALF) clk = ~clk;

  sbk_mem_array #(
    .NUM_SUBBANKS(NSB), .ADDR_W(AW), .DATA_W(DW), .WRITE_CYCLES(WC)
  ) i_sbk_mem_array (
    .clk(clk), .rst(rst),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
    .sb_busy(sb_busy)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // ---------------- behavioural reference ----------------
  int unsigned m_mem [WORDS];
  int          m_cnt [NSB];
  int unsigned m_baddr [NSB];
  int unsigned m_bdata [NSB];
  bit          m_rv;
  int unsigned m_rd;
  string       m_rtag;

  function automatic int sb_of(input int unsigned a);
    return a % NSB;   // striped mapping, R9
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int a = 0; a < WORDS; a++) m_mem[a] = 0;
      for (int s = 0; s < NSB; s++) begin m_cnt[s] = 0; m_baddr[s] = 0; m_bdata[s] = 0; end
      m_rv = 0; m_rd = 0; m_rtag = "R1";
    end else begin
      int ws;
      bit take;
      ws = sb_of(wr_addr);
      take = wr_valid && (m_cnt[ws] == 0);
      m_rv = rd_valid;
      if (rd_valid) begin
        int rs;
        rs = sb_of(rd_addr);
        if (m_cnt[rs] != 0 && m_baddr[rs] == rd_addr) begin
          m_rd = m_bdata[rs]; m_rtag = "R6";
        end else begin
          m_rd = m_mem[rd_addr]; m_rtag = "R8";
        end
      end
      for (int s = 0; s < NSB; s++) begin
        if (m_cnt[s] != 0) begin
          m_cnt[s]--;
          if (m_cnt[s] == 0) m_mem[m_baddr[s]] = m_bdata[s];
        end
      end
      if (take && m_mem[wr_addr] != wr_data) begin
        m_cnt[ws] = WC; m_baddr[ws] = wr_addr; m_bdata[ws] = wr_data;
      end
    end
  end

  task automatic fail_line(input string tag, input string what, input int unsigned act,
                           input int unsigned exp);
    n_bad++;
    $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
  endtask

  // comparison on every clock, at the falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      bit er;
      logic [NSB-1:0] eb;
      er = (m_cnt[sb_of(wr_addr)] == 0);
      for (int s = 0; s < NSB; s++) eb[s] = (m_cnt[s] != 0);
      n_cmp++;
      if (wr_ready !== er) fail_line("R2", "wr_ready", wr_ready, er);
      n_cmp++;
      if (sb_busy !== eb) fail_line("R3", "sb_busy", sb_busy, eb);
      n_cmp++;
      if (rd_resp_valid !== m_rv) fail_line("R5", "rd_resp_valid", rd_resp_valid, m_rv);
      if (m_rv) begin
        n_cmp++;
        if (rd_resp_data !== DW'(m_rd)) fail_line(m_rtag, "rd_resp_data", rd_resp_data, m_rd);
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic do_write(input int unsigned a, input int unsigned d);
    bit acc;
    wr_valid = 1; wr_addr = AW'(a); wr_data = DW'(d);
    forever begin
      @(negedge clk); acc = wr_ready;
      step();
      if (acc) break;
    end
    wr_valid = 0;
  endtask

  // read issued now, response checked against an explicit value
  task automatic read_expect(input int unsigned a, input int unsigned d, input string tag);
    rd_valid = 1; rd_addr = AW'(a);
    step();
    rd_valid = 0;
    @(negedge clk);
    n_cmp++;
    if (rd_resp_valid !== 1'b1 || rd_resp_data !== DW'(d))
      fail_line(tag, "directed read", rd_resp_data, d);
    step();
  endtask

  task automatic expect_busy(input logic [NSB-1:0] e, input string tag);
    @(negedge clk);
    n_cmp++;
    if (sb_busy !== e) fail_line(tag, "directed busy", sb_busy, e);
    step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(2.0 * HALF * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    bit acc;
    repeat (3) @(posedge clk);
    #2 rst = 0;
    // R1: reset state
    @(negedge clk);
    n_cmp++;
    if (sb_busy !== '0 || wr_ready !== 1'b1 || rd_resp_valid !== 1'b0)
      fail_line("R1", "reset outputs", {sb_busy, wr_ready, rd_resp_valid}, 32'h2);
    step();
    read_expect(7, 0, "R1");
    read_expect(40, 0, "R1");

    // R3/R6/R7: park a write in subbank 1, read around it
    do_write(5, 16'hA5A5);
    expect_busy(4'b0010, "R3");
    read_expect(5, 16'hA5A5, "R6");
    read_expect(9, 0, "R7");
    // R3: another subbank accepts while subbank 1 is busy
    do_write(6, 16'h1234);
    // R2: same subbank stalls until free
    do_write(13, 16'h00FF);
    repeat (WC + 2) step();
    // R8: committed contents
    read_expect(5, 16'hA5A5, "R8");
    read_expect(6, 16'h1234, "R8");
    read_expect(13, 16'h00FF, "R8");

    // R4: identical data leaves subbank free
    do_write(5, 16'hA5A5);
    @(negedge clk);
    n_cmp++;
    if (sb_busy[1] !== 1'b0 || wr_ready !== 1'b1) fail_line("R4", "zero-diff busy", sb_busy, 0);
    step();
    // R8: partial bit change still lands as full word
    do_write(5, 16'hA5A4);
    repeat (WC + 1) step();
    read_expect(5, 16'hA5A4, "R8");

    // R10: read and write of the same address on one edge
    rd_valid = 1; rd_addr = 12;
    do_write(12, 16'hBEEF);
    rd_valid = 0;
    @(negedge clk);
    n_cmp++;
    if (rd_resp_data !== 16'h0000) fail_line("R10", "read-before-write", rd_resp_data, 0);
    step();
    repeat (WC + 1) step();

    // R9: registers 0..3 of thread 2 go to four subbanks back to back
    for (int r = 0; r < 4; r++) do_write(2 * 16 + r, 16'h0100 + r);
    expect_busy(4'b1111, "R9");
    repeat (WC + 1) step();
    for (int r = 0; r < 4; r++) read_expect(2 * 16 + r, 16'h0100 + r, "R9");

    // mixed traffic, checked by the reference on every clock
    for (int i = 0; i < 3000; i++) begin
      if (!wr_valid || acc) begin
        wr_valid = ($urandom % 3) != 0;
        wr_addr  = AW'($urandom % WORDS);
        wr_data  = DW'($urandom % 4);
      end
      rd_valid = ($urandom % 2) != 0;
      rd_addr  = AW'($urandom % WORDS);
      @(negedge clk); acc = wr_valid && wr_ready;
      step();
    end
    wr_valid = 0; rd_valid = 0;
    repeat (WC + 2) step();
    finish_run();
  end

endmodule